// File: doc/BRIEF.md
# Oscillator Failure Supervisor

This block supervises a slow oscillator (nominally 32.768 kHz) from a much faster reference clock. The oscillator reaches the block as a plain sampled input. A free-running idle counter in the reference domain measures the time since the last transition of that input, either rising or falling. When the idle time reaches a limit, the block declares the oscillator dead. It then requests an oscillator restart, holds the system in reset, and forces a group of functional outputs to a fixed safe pattern.

A dead oscillator is only accepted as running again after a set number of consecutive transitions, each arriving before the idle limit expires. At that point the restart and reset requests are released together. A sticky fault bit is set in the status word, and the device is forced into run mode. The run-mode status bit is left exactly as it was. Outside of fault handling, host strobes enter run mode, fall back to wait mode, and clear the two live status bits.

Top module: `osc_fail_sup`

## Requirements
- R1: After reset, `sysReset`, `oscRestart` and `runMode` are 0, `statusReg` is 8'h00, and `safeOut` follows `funcIn`. Status bits other than bit 5 and bit 2 always read 0.
- R2: No failure is declared while the sampled oscillator changes level at least once every `TIMEOUT_CYC-2` reference cycles, for any half-period from 1 up to that bound.
- R3: When the oscillator stops, both `sysReset` and `oscRestart` go to 1 no earlier than `TIMEOUT_CYC` and no later than `TIMEOUT_CYC+4` reference cycles after the last level change.
- R4: While `sysReset` is 1, `safeOut` equals `SAFE_VALUE` whatever `funcIn` holds. Otherwise `safeOut` equals `funcIn`.
- R5: Recovery needs `GOOD_EDGES` level changes. After `GOOD_EDGES-1` changes the failure persists. Within 4 reference cycles of the `GOOD_EDGES`-th change, `sysReset` and `oscRestart` both return to 0.
- R6: A pause longer than `TIMEOUT_CYC` during recovery discards the level changes counted so far.
- R7: On recovery, status bit 5 (oscillator fault) becomes 1 and `runMode` becomes 1. Status bit 5 never becomes 1 at any other time.
- R8: Failure and recovery leave status bit 2 (run entered) unchanged, whether it is 0 or 1.
- R9: Status bit 5 stays 1 until a `clrFault` pulse. That pulse clears bit 5 only.
- R10: A `runEnterReq` pulse sets `runMode` and status bit 2. A `waitReq` pulse clears `runMode` only. A `clrRun` pulse clears status bit 2 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscIn | input | 1 | Sampled oscillator level (asynchronous) |
| funcIn | input | OUT_W | Functional output values in normal operation |
| runEnterReq | input | 1 | Strobe: enter run mode and set status bit 2 |
| waitReq | input | 1 | Strobe: enter wait mode |
| clrRun | input | 1 | Strobe: clear status bit 2 |
| clrFault | input | 1 | Strobe: clear status bit 5 |
| sysReset | output | 1 | System reset request during failure |
| oscRestart | output | 1 | Oscillator restart request during failure |
| runMode | output | 1 | 1 = run mode, 0 = wait mode |
| statusReg | output | 8 | Status word: bit 5 fault, bit 2 run entered |
| safeOut | output | OUT_W | Functional outputs, forced to SAFE_VALUE in failure |

## Verification
The hardest situation to reach is a recovery that is interrupted partway, because it needs a failure first, then a burst of edges one short of the threshold, then a pause of exactly the right length. A background toggler in the bench counts every level change it makes. The stimulus waits on that count to stop the oscillator after a chosen number of edges, so the partial count is known exactly before the pause starts. Both polarities of status bit 2 are carried through a complete failure and recovery, to show that the bit is left alone.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;
  localparam int STATUS_W  = 8;
  localparam int FAULT_BIT = 5;
  localparam int RUN_BIT   = 2;

  // control -> datapath
  typedef struct packed {
    logic countGood;
    logic clearGood;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic starved;
    logic recovered;
  } dpFlags_t;

  typedef enum logic {
    ST_RUNNING = 1'b0,
    ST_FAILED  = 1'b1
  } supState_t;
endpackage

// File: rtl/osc_sup_dp.sv
module osc_sup_dp
  import osc_sup_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2048,
  parameter int GOOD_EDGES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscIn,
  input  dpStrobe_t  strobe,
  output dpFlags_t   flags
);
  localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);
  localparam int GOOD_W = $clog2(GOOD_EDGES + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(TIMEOUT_CYC);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(GOOD_EDGES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   oscPrev;
  logic                   oscEdge;
  logic [IDLE_W-1:0]      idleCnt;
  logic [GOOD_W-1:0]      goodCnt;
  logic                   starved;

  // synchronizer chain into the reference domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      oscPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], oscIn};
      oscPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  // either polarity counts as activity
  assign oscEdge = syncQ[SYNC_STAGES-1] ^ oscPrev;

  // saturating idle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 idleCnt <= '0;
    else if (oscEdge)          idleCnt <= '0;
    else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
  end

  assign starved = (idleCnt == IDLE_MAX) && !oscEdge;

  // consecutive good-edge counter used during recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      goodCnt <= '0;
    else if (strobe.clearGood || starved)
      goodCnt <= '0;
    else if (strobe.countGood && oscEdge && goodCnt != GOOD_MAX)
      goodCnt <= goodCnt + 1'b1;
  end

  assign flags.starved   = starved;
  assign flags.recovered = (goodCnt == GOOD_MAX);
endmodule

// File: rtl/osc_sup_ctrl.sv
module osc_sup_ctrl
  import osc_sup_pkg::*;
#(
  parameter int               OUT_W      = 4,
  parameter logic [OUT_W-1:0] SAFE_VALUE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpFlags_t            flags,
  input  logic [OUT_W-1:0]    funcIn,
  input  logic                runEnterReq,
  input  logic                waitReq,
  input  logic                clrRun,
  input  logic                clrFault,
  output dpStrobe_t           strobe,
  output logic                failActive,
  output logic                runMode,
  output logic [STATUS_W-1:0] statusReg,
  output logic [OUT_W-1:0]    safeOut
);
  supState_t state, stateNext;
  logic      recoverNow;
  logic      faultBit;
  logic      runBit;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUNNING: if (flags.starved)   stateNext = ST_FAILED;
      ST_FAILED:  if (flags.recovered) stateNext = ST_RUNNING;
      default:                         stateNext = ST_RUNNING;
    endcase
  end

  assign recoverNow = (state == ST_FAILED) && flags.recovered;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUNNING;
    else       state <= stateNext;
  end

  // recovery forces run mode; host strobes act otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            runMode <= 1'b0;
    else if (recoverNow)  runMode <= 1'b1;
    else if (runEnterReq) runMode <= 1'b1;
    else if (waitReq)     runMode <= 1'b0;
  end

  // sticky fault bit, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           faultBit <= 1'b0;
    else if (recoverNow) faultBit <= 1'b1;
    else if (clrFault)   faultBit <= 1'b0;
  end

  // run-entered bit, untouched by fault handling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            runBit <= 1'b0;
    else if (runEnterReq) runBit <= 1'b1;
    else if (clrRun)      runBit <= 1'b0;
  end

  always_comb begin
    statusReg            = '0;
    statusReg[FAULT_BIT] = faultBit;
    statusReg[RUN_BIT]   = runBit;
  end

  assign failActive       = (state == ST_FAILED);
  assign strobe.countGood = (state == ST_FAILED);
  assign strobe.clearGood = (state == ST_RUNNING);
  assign safeOut          = failActive ? SAFE_VALUE : funcIn;
endmodule

// File: rtl/osc_fail_sup.sv
module osc_fail_sup
  import osc_sup_pkg::*;
#(
  parameter int               TIMEOUT_CYC = 2048,
  parameter int               GOOD_EDGES  = 8,
  parameter int               OUT_W       = 4,
  parameter logic [OUT_W-1:0] SAFE_VALUE  = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscIn,
  input  logic [OUT_W-1:0] funcIn,
  input  logic             runEnterReq,
  input  logic             waitReq,
  input  logic             clrRun,
  input  logic             clrFault,
  output logic             sysReset,
  output logic             oscRestart,
  output logic             runMode,
  output logic [7:0]       statusReg,
  output logic [OUT_W-1:0] safeOut
);
  dpStrobe_t strobe;
  dpFlags_t  flags;
  logic      failActive;

  osc_sup_dp #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .GOOD_EDGES (GOOD_EDGES),
    .SYNC_STAGES(2)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .oscIn (oscIn),
    .strobe(strobe),
    .flags (flags)
  );

  osc_sup_ctrl #(
    .OUT_W     (OUT_W),
    .SAFE_VALUE(SAFE_VALUE)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .flags      (flags),
    .funcIn     (funcIn),
    .runEnterReq(runEnterReq),
    .waitReq    (waitReq),
    .clrRun     (clrRun),
    .clrFault   (clrFault),
    .strobe     (strobe),
    .failActive (failActive),
    .runMode    (runMode),
    .statusReg  (statusReg),
    .safeOut    (safeOut)
  );

  assign sysReset   = failActive;
  assign oscRestart = failActive;
endmodule

// File: rtl/osc_sup_chk.sv
module osc_sup_chk #(
  parameter int               OUT_W      = 4,
  parameter logic [OUT_W-1:0] SAFE_VALUE = '0
) (
  input logic             clk,
  input logic             rstN,
  input logic             sysReset,
  input logic             runMode,
  input logic [7:0]       statusReg,
  input logic [OUT_W-1:0] safeOut,
  input logic             runEnterReq,
  input logic             clrRun,
  input logic             clrFault
);
  // R1
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & 8'hDB) == 8'h00);

  // R4
  safe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |-> safeOut == SAFE_VALUE);

  // R7
  recover_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysReset) |-> (statusReg[5] && runMode));

  // R7
  fault_bit_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[5]) |-> $fell(sysReset));

  // R8
  run_bit_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sysReset) && !$past(runEnterReq) && !$past(clrRun))
      |-> statusReg[2] == $past(statusReg[2]));

  // R9
  fault_bit_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[5]) |-> $past(clrFault));
endmodule

bind osc_fail_sup osc_sup_chk #(
  .OUT_W     (OUT_W),
  .SAFE_VALUE(SAFE_VALUE)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sysReset   (sysReset),
  .runMode    (runMode),
  .statusReg  (statusReg),
  .safeOut    (safeOut),
  .runEnterReq(runEnterReq),
  .clrRun     (clrRun),
  .clrFault   (clrFault)
);

// File: tb/osc_fail_sup_tb_top.sv
module osc_fail_sup_tb_top;
  localparam int         T    = 12;
  localparam int         G    = 4;
  localparam int         W    = 4;
  localparam logic [3:0] SAFE = 4'hA;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rstN, oscIn, runEnterReq, waitReq, clrRun, clrFault;
  logic [W-1:0] funcIn, safeOut;
  logic         sysReset, oscRestart, runMode;
  logic [7:0]   statusReg;

  int checks = 0;
  int fails  = 0;
  int oscRun = 0;
  int halfPer = 3;
  int togCnt = 0;
  int edgeCnt = 0;

  osc_fail_sup #(
    .TIMEOUT_CYC(T), .GOOD_EDGES(G), .OUT_W(W), .SAFE_VALUE(SAFE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .funcIn(funcIn),
    .runEnterReq(runEnterReq), .waitReq(waitReq), .clrRun(clrRun),
    .clrFault(clrFault), .sysReset(sysReset), .oscRestart(oscRestart),
    .runMode(runMode), .statusReg(statusReg), .safeOut(safeOut)
  );

  // background oscillator model, driven on falling edges
  always @(negedge clk) begin
    if (oscRun != 0) begin
      togCnt = togCnt + 1;
      if (togCnt >= halfPer) begin
        oscIn   = ~oscIn;
        togCnt  = 0;
        edgeCnt = edgeCnt + 1;
      end
    end else begin
      togCnt = 0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // 0 run enter, 1 wait, 2 clear run bit, 3 clear fault bit
  task automatic pulse(input int which);
    case (which)
      0: runEnterReq = 1'b1;
      1: waitReq     = 1'b1;
      2: clrRun      = 1'b1;
      default: clrFault = 1'b1;
    endcase
    cyc(1);
    runEnterReq = 1'b0; waitReq = 1'b0; clrRun = 1'b0; clrFault = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int e;
    int hits;
    rstN = 1'b0; oscIn = 1'b0; funcIn = 4'd5;
    runEnterReq = 1'b0; waitReq = 1'b0; clrRun = 1'b0; clrFault = 1'b0;
    cyc(3);
    oscRun = 1;
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 sysReset", int'(sysReset), 0);
    chk("R1 oscRestart", int'(oscRestart), 0);
    chk("R1 runMode", int'(runMode), 0);
    chk("R1 statusReg", int'(statusReg), 0);
    chk("R1 safeOut", int'(safeOut), 5);

    // R10 host strobes
    pulse(0);
    chk("R10 runMode after enter", int'(runMode), 1);
    chk("R10 bit2 after enter", int'(statusReg[2]), 1);
    pulse(1);
    chk("R10 runMode after wait", int'(runMode), 0);
    chk("R10 bit2 kept by wait", int'(statusReg[2]), 1);
    pulse(2);
    chk("R10 bit2 cleared", int'(statusReg[2]), 0);
    chk("R10 runMode kept by clear", int'(runMode), 0);
    pulse(0);
    pulse(1);

    // R2 sweep of half-periods, R4 pass-through
    for (int h = 1; h <= T - 2; h++) begin
      halfPer = h;
      funcIn  = 4'(h);
      hits    = 0;
      repeat (4 * T) begin
        cyc(1);
        if (sysReset) hits++;
      end
      chk($sformatf("R2 no failure at half-period %0d", h), hits, 0);
      chk("R4 pass-through", int'(safeOut), h);
    end

    // R3 failure timing
    halfPer = 2;
    cyc(10);
    oscRun = 0;
    cyc(T - 3);
    chk("R3 not yet failed", int'(sysReset), 0);
    cyc(9);
    chk("R3 sysReset", int'(sysReset), 1);
    chk("R3 oscRestart", int'(oscRestart), 1);
    for (int v = 0; v < 16; v++) begin
      funcIn = 4'(v);
      cyc(1);
      chk("R4 safe value", int'(safeOut), int'(SAFE));
    end
    funcIn = 4'd5;
    chk("R8 bit2 during failure", int'(statusReg[2]), 1);
    chk("R7 bit5 not before recovery", int'(statusReg[5]), 0);

    // R6 interrupted recovery
    e = edgeCnt; halfPer = 3; oscRun = 1;
    wait (edgeCnt == e + G - 1);
    oscRun = 0;
    cyc(T + 6);
    chk("R6 still failed after pause", int'(sysReset), 1);

    // R5 edge threshold
    e = edgeCnt; halfPer = 5; oscRun = 1;
    wait (edgeCnt == e + G - 1);
    cyc(4);
    chk("R5 failed one edge short", int'(sysReset), 1);
    wait (edgeCnt == e + G);
    cyc(5);
    chk("R5 sysReset released", int'(sysReset), 0);
    chk("R5 oscRestart released", int'(oscRestart), 0);
    chk("R7 fault bit set", int'(statusReg[5]), 1);
    chk("R7 run mode forced", int'(runMode), 1);
    chk("R8 bit2 kept at 1", int'(statusReg[2]), 1);
    chk("R4 pass-through after recovery", int'(safeOut), 5);

    // R9 sticky fault bit
    halfPer = 3;
    cyc(20);
    chk("R9 fault bit sticky", int'(statusReg[5]), 1);
    pulse(3);
    chk("R9 fault bit cleared", int'(statusReg[5]), 0);
    chk("R9 bit2 untouched by clear", int'(statusReg[2]), 1);
    chk("R9 runMode untouched by clear", int'(runMode), 1);

    // R8 with bit2 at 0
    pulse(2);
    pulse(1);
    chk("R10 wait mode before second fault", int'(runMode), 0);
    oscRun = 0;
    cyc(T + 6);
    chk("R3 second failure", int'(sysReset), 1);
    e = edgeCnt; halfPer = 3; oscRun = 1;
    wait (edgeCnt == e + G);
    cyc(6);
    chk("R5 second release", int'(sysReset), 0);
    chk("R8 bit2 kept at 0", int'(statusReg[2]), 0);
    chk("R7 run mode forced again", int'(runMode), 1);
    chk("R7 fault bit set again", int'(statusReg[5]), 1);
    chk("R1 spare status bits", int'(statusReg & 8'hDB), 0);

    finish_run();
  end
endmodule